// File: doc/BRIEF.md
# Embedded-Sync Digital Video Receiver

The block takes a component video byte stream, 8 or 10 bits per word, in which the line and field timing travel inside the data as four-word timing references. It finds these references and reads the field, vertical-blanking and end/start flags from their status word. It then passes a chosen part of the stream to an output port. Three selections are available: only the active picture samples of a limited number of lines, only the vertical-blanking content, or the whole stream. Nothing is forwarded until the receiver has locked to the start of the first field.

Both data ports use valid/ready handshakes. A word moves on a port in a cycle where its valid and ready are both high. The output has a single register stage. `in_ready` is high whenever that stage is empty or is being emptied in the same cycle. Back-pressure on `out_ready` therefore stalls the input one for one, and this includes words that the receiver would discard. `mode` and `line_limit` are plain control levels. They are meant to change only while the block is in reset.

Top module: `vid656_rx`

## Requirements
- R1: A timing reference is an all-ones word, then two all-zeros words, then a status word. In the status word, bit DATA_W-2 is the field flag F, bit DATA_W-3 is the vertical-blanking flag V, and bit DATA_W-4 is H (1 = end of active video, 0 = start of active video).
- R2: No word is forwarded before lock. Lock happens at a status word with F=0 and V=1 when the previous status word had F=1. Lock then holds until reset.
- R3: With `mode` 2 or 3 (whole stream), every word accepted after the locking status word is forwarded unchanged and in order. Timing references are included in this.
- R4: With `mode` 0 (active picture), only words that follow a start-of-active-video status with V=0 are forwarded, up to the next timing reference. An all-ones word is never forwarded, and neither is any other word that belongs to a timing reference.
- R5: In `mode` 0, each start-of-active-video status with V=0 counts one line. Only the first `line_limit` such lines after each field-1 start are forwarded. The count restarts at every field-1 start, and a limit of 0 forwards nothing.
- R6: With `mode` 1 (vertical blanking), words that are not part of a timing reference are forwarded after a status word with V=1 and until a status word with V=0.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_data` holds its value and `in_ready` is low.
- R8: After reset, `out_valid` is low, `in_ready` is high and the receiver is unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0 active picture, 1 vertical blanking, 2/3 whole stream |
| line_limit | input | LINE_W | Active lines forwarded per frame in mode 0 |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | DATA_W | Input video word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer accepts output word |
| out_data | output | DATA_W | Forwarded video word |

## Verification
If the reference tracker loses its position, the damage shows on the next word. A timing word leaks into the active-picture output, or a picture word goes missing. A stale field flag leaves the output silent after the field-1 start, or the output starts on the wrong word. A line counter that miscounts shows within one frame, because a whole line appears or disappears at the limit boundary. The scoreboard compares every output word in order, so each of these faults is seen as soon as its first word is due.

// File: rtl/vrx_pkg.sv
package vrx_pkg;

  typedef enum logic [1:0] {
    MODE_ACTIVE   = 2'd0,
    MODE_BLANK    = 2'd1,
    MODE_FULL     = 2'd2,
    MODE_FULL_ALT = 2'd3
  } mode_e;

  // position inside a timing reference candidate
  typedef enum logic [1:0] {
    TRS_IDLE  = 2'd0,
    TRS_ONE   = 2'd1,
    TRS_TWO   = 2'd2,
    TRS_THREE = 2'd3
  } trs_pos_e;

  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } trs_status_t;

endpackage

// File: rtl/vrx_trs_detect.sv
module vrx_trs_detect #(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  step,
  input  logic [DATA_W-1:0]     word,
  output logic                  part,
  output logic                  hit,
  output vrx_pkg::trs_status_t  status
);
  import vrx_pkg::*;

  localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] ZERO = '0;
  localparam int F_BIT = DATA_W - 2;
  localparam int V_BIT = DATA_W - 3;
  localparam int H_BIT = DATA_W - 4;

  trs_pos_e pos_q, pos_d;

  always_comb begin
    pos_d = pos_q;
    part  = 1'b0;
    hit   = 1'b0;
    unique case (pos_q)
      TRS_IDLE: begin
        if (word == ONES) begin
          part  = 1'b1;
          pos_d = TRS_ONE;
        end
      end
      TRS_ONE, TRS_TWO: begin
        if (word == ZERO) begin
          part  = 1'b1;
          pos_d = (pos_q == TRS_ONE) ? TRS_TWO : TRS_THREE;
        end else if (word == ONES) begin
          part  = 1'b1;
          pos_d = TRS_ONE;
        end else begin
          pos_d = TRS_IDLE;
        end
      end
      TRS_THREE: begin
        part  = 1'b1;
        hit   = 1'b1;
        pos_d = TRS_IDLE;
      end
      default: pos_d = TRS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= TRS_IDLE;
    end else if (step) begin
      pos_q <= pos_d;
    end
  end

  assign status.f = word[F_BIT];
  assign status.v = word[V_BIT];
  assign status.h = word[H_BIT];

endmodule

// File: rtl/vrx_region_track.sv
module vrx_region_track #(
  parameter int LINE_W = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hit,
  input  vrx_pkg::trs_status_t status,
  input  logic [LINE_W-1:0]    line_limit,
  output logic                 locked,
  output logic                 lock_evt,
  output logic                 in_active,
  output logic                 line_ok,
  output logic                 vblank,
  output logic [LINE_W-1:0]    line_cnt
);

  logic prev_f;
  logic room;

  assign lock_evt = hit && !status.f && status.v && prev_f;
  assign room     = line_cnt < line_limit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked    <= 1'b0;
      prev_f    <= 1'b0;
      vblank    <= 1'b0;
      in_active <= 1'b0;
      line_ok   <= 1'b0;
      line_cnt  <= '0;
    end else if (hit) begin
      prev_f <= status.f;
      vblank <= status.v;
      if (lock_evt) begin
        locked   <= 1'b1;
        line_cnt <= '0;
      end
      if (status.h) begin
        in_active <= 1'b0;
      end else begin
        in_active <= !status.v;
        if (!status.v) begin
          line_ok <= room;
          if (room) begin
            line_cnt <= line_cnt + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/vrx_out_stage.sv
module vrx_out_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              space
);

  assign space = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= din;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/vid656_rx.sv
module vid656_rx #(
  parameter int DATA_W = 8,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [LINE_W-1:0] line_limit,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  import vrx_pkg::*;

  logic              accept;
  logic              part;
  logic              hit;
  trs_status_t       status;
  logic              locked;
  logic              lock_evt;
  logic              in_active;
  logic              line_ok;
  logic              vblank;
  logic [LINE_W-1:0] line_cnt;
  logic              fwd;
  logic              fire;

  assign accept = in_valid && in_ready;

  vrx_trs_detect #(.DATA_W(DATA_W)) u_detect (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (accept),
    .word   (in_data),
    .part   (part),
    .hit    (hit),
    .status (status)
  );

  vrx_region_track #(.LINE_W(LINE_W)) u_region (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit        (accept && hit),
    .status     (status),
    .line_limit (line_limit),
    .locked     (locked),
    .lock_evt   (lock_evt),
    .in_active  (in_active),
    .line_ok    (line_ok),
    .vblank     (vblank),
    .line_cnt   (line_cnt)
  );

  always_comb begin
    unique case (mode_e'(mode))
      MODE_ACTIVE: fwd = locked && in_active && line_ok && !part;
      MODE_BLANK:  fwd = locked && vblank && !part;
      default:     fwd = locked;
    endcase
  end

  assign fire = accept && fwd;

  vrx_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (fire),
    .din       (in_data),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .space     (in_ready)
  );

endmodule

// File: rtl/vid656_rx_chk.sv
module vid656_rx_chk #(
  parameter int DATA_W = 8,
  parameter int LINE_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              locked,
  input logic              lock_evt,
  input logic [LINE_W-1:0] line_cnt,
  input logic              fire
);

  localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};

  a_r7_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r7_stall_input: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r2_no_output_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(locked));

  a_r2_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  a_r4_no_ones_filtered: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (mode == 2'd0 || mode == 2'd1)) |-> (in_data != ONES));

  a_r5_count_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_evt |=> (line_cnt >= $past(line_cnt)));

endmodule

bind vid656_rx vid656_rx_chk #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode      (mode),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .locked    (locked),
  .lock_evt  (lock_evt),
  .line_cnt  (line_cnt),
  .fire      (fire)
);

// File: tb/tb_vid656_rx.sv
`timescale 1ns/1ps
module tb_vid656_rx;
  localparam int DW = 8;
  localparam int LW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic [LW-1:0] line_limit = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [DW-1:0] out_data;

  always #2.5 clk = ~clk;

  vid656_rx #(.DATA_W(DW), .LINE_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .line_limit(line_limit),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  typedef struct {
    logic [DW-1:0] d;
    string         tag;
  } item_t;

  item_t expq[$];
  int    n_chk = 0;
  int    n_fail = 0;
  bit    stall_en = 0;
  bit    done = 0;
  string cur_tag = "R3";

  // bench model of the requirements
  bit m_lock, m_prevf, m_vb, m_act, m_ok;
  int m_cnt;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // out_ready pattern changes just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      out_ready = stall_en ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  // monitor / scoreboard
  logic [DW-1:0] held;
  bit            was_stalled = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (was_stalled)
        chk(out_valid && out_data == held, "R7 hold", {out_valid, out_data}, {1'b1, held});
      if (out_valid && !out_ready)
        chk(!in_ready, "R7 ready", in_ready, 0);
      was_stalled = out_valid && !out_ready;
      held = out_data;
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          chk(0, "R2/R4/R5/R6 unexpected word", out_data, 0);
        end else begin
          item_t it;
          it = expq.pop_front();
          chk(out_data == it.d, it.tag, out_data, it.d);
        end
      end
    end else begin
      was_stalled = 0;
    end
  end

  task automatic drive(input logic [DW-1:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic push_if(input bit e, input logic [DW-1:0] w);
    if (e) expq.push_back('{w, cur_tag});
  endtask

  task automatic send_tr(input bit f, input bit v, input bit h);
    bit e;
    logic [DW-1:0] st;
    e  = mode[1] && m_lock;
    st = {1'b1, f, v, h, 4'b0000};
    push_if(e, 8'hFF); drive(8'hFF);
    push_if(e, 8'h00); drive(8'h00);
    push_if(e, 8'h00); drive(8'h00);
    push_if(e, st);    drive(st);
    if (!f && v && m_prevf) begin
      m_lock = 1;
      m_cnt  = 0;
    end
    m_prevf = f;
    m_vb    = v;
    if (h) m_act = 0;
    else begin
      m_act = !v;
      if (!v) begin
        m_ok = m_cnt < line_limit;
        if (m_ok) m_cnt++;
      end
    end
  endtask

  task automatic send_data(input logic [DW-1:0] w);
    bit e;
    if (mode[1]) e = m_lock;
    else if (w == 8'hFF) e = 0;
    else if (mode == 2'd0) e = m_lock && m_act && m_ok;
    else e = m_lock && m_vb;
    push_if(e, w);
    drive(w);
  endtask

  task automatic send_line(input bit f, input bit v, input int ln);
    send_tr(f, v, 1'b1);
    for (int i = 0; i < 3; i++) send_data(8'h10 + i[7:0]);
    send_tr(f, v, 1'b0);
    for (int i = 0; i < 4; i++) send_data(8'h40 + ln[7:0] * 4 + i[7:0]);
  endtask

  task automatic run_frames();
    int ln;
    ln = 0;
    for (int i = 0; i < 2; i++) send_line(1, 1, ln++);  // field 2 blanking, unlocked
    send_line(1, 0, ln++);                              // field 2 active, unlocked
    for (int i = 0; i < 2; i++) send_line(0, 1, ln++);  // field 1 start: lock
    send_line(0, 0, ln++);
    send_data(8'hFF);                                   // lone all-ones inside a line
    send_data(8'h55);
    for (int i = 0; i < 3; i++) send_line(0, 0, ln++);
    send_line(1, 1, ln++);
    for (int i = 0; i < 2; i++) send_line(1, 0, ln++);
    send_line(0, 1, ln++);                              // next frame: count restarts
    for (int i = 0; i < 3; i++) send_line(0, 0, ln++);
    send_tr(1, 1, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_reset(input logic [1:0] md, input logic [LW-1:0] lim, input bit st);
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    mode = md;
    line_limit = lim;
    stall_en = st;
    expq.delete();
    m_lock = 0; m_prevf = 0; m_vb = 0; m_act = 0; m_ok = 0; m_cnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 500 && expq.size() != 0; i++) @(posedge clk);
    repeat (20) @(posedge clk);
    chk(expq.size() == 0, tag, expq.size(), 0);
  endtask

  initial begin
    do_reset(2'd2, 8'd3, 0);
    chk(out_valid == 1'b0, "R8 out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R8 in_ready", in_ready, 1);

    cur_tag = "R3 whole stream";
    do_reset(2'd2, 8'd3, 1);
    run_frames();
    drain("R2 R3 drain");

    cur_tag = "R1 R4 R5 active";
    do_reset(2'd0, 8'd3, 0);
    run_frames();
    drain("R1 R4 R5 drain");

    cur_tag = "R6 blanking";
    do_reset(2'd1, 8'd3, 1);
    run_frames();
    drain("R6 drain");

    cur_tag = "R5 zero limit";
    do_reset(2'd0, 8'd0, 0);
    run_frames();
    drain("R5 drain");

    cur_tag = "R3 alt code";
    do_reset(2'd3, 8'd1, 1);
    run_frames();
    drain("R3 alt drain");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule